// File: doc/BRIEF.md
# Guarded Control Register Write Sequencer

This block holds an 8-bit control register that a two-wire slave front end reaches through byte writes to one fixed address, FFFFh by default. The register carries two volatile enable latches and five nonvolatile configuration bits: two watchdog period bits and three block protection bits. A write can change the nonvolatile bits only after an unlock sequence of three separate write transactions. The first write arms the write-enable latch, the second arms the register-write latch, and the third loads the configuration and disarms the register-write latch. The commit starts a nonvolatile cycle that lasts a fixed number of clock cycles. While that cycle runs, register writes are refused.

The front end reports each transaction as single-cycle strobes: a write address, the first data byte, any further data byte, a STOP, and the start of a read. The block answers every first or further data byte to its address with a one-cycle ACK/NACK decision. It applies an accepted byte only when a STOP closes that transaction. A write to a protected array block is reported on its own strobe and disarms the register-write latch.

The strobes come from bit-level bus timing that cannot wait, so they carry no ready signal. Each strobe is consumed in the cycle it is seen. Back-pressure to the bus master is expressed only as a NACK. At most one strobe may be high in any cycle.

Top module: `creg_guard_seq`

## Requirements
- R1: After power-on reset (por_n low), the write-enable latch, the register-write latch, busy, nv_start and resp_vld are all 0, and the watchdog and protection bits keep the values they held before the reset.
- R2: While the write-enable latch is clear, a data byte to the register address other than 02h gets a NACK (resp_vld=1, resp_ack=0) and changes nothing.
- R3: A data byte of 02h gets an ACK even with the write-enable latch clear, and after a valid STOP the write-enable latch (creg bit 1) is set, with no busy cycle.
- R4: With the write-enable latch set and the register-write latch clear, a STOP-terminated write of 06h sets the register-write latch (creg bit 2), with no busy cycle.
- R5: With both latches set, a STOP-terminated write whose bit 2 is 0 and bit 1 is 1 loads data bits 6:5 into the watchdog bits and data bits 4, 3 and 0 into the protection bits. It also clears the register-write latch, pulses nv_start for exactly one cycle, and holds busy high for NV_CYCLES cycles.
- R6: With both latches set, a STOP-terminated write with bit 2 = 1 leaves the nonvolatile bits unchanged and the register-write latch set. The sequence 02h, 06h, 06h changes no nonvolatile bit, while 02h, 06h, 02h clears all of them.
- R7: A STOP-terminated write of 00h clears the write-enable latch.
- R8: A second data byte in one register write gets a NACK, and the whole write is discarded.
- R9: A register write that ends without a STOP after an accepted data byte (a STOP before the data byte, or a repeated start into a read or another write) is discarded. A write to any other address gets no response and leaves the register unchanged.
- R10: A read transaction between the unlock steps does not disturb either latch or the sequence.
- R11: A pulse on prot_wr clears the register-write latch.
- R12: While busy is high, every data byte to the register address gets a NACK.
- R13: Register layout: bit 7 reads 0 whatever was written, bit 6 WD1, bit 5 WD0, bit 4 BP2, bit 3 BP1, bit 2 register-write latch, bit 1 write-enable latch, bit 0 BP0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| addr_vld | input | 1 | Strobe: write transaction addressed, address on addr |
| addr | input | ADDR_W | Word address of the write transaction |
| rd_vld | input | 1 | Strobe: a read transaction has started |
| byte_vld | input | 1 | Strobe: first data byte received, value on byte_data |
| byte_data | input | 8 | Data byte |
| more_vld | input | 1 | Strobe: a further data byte in the same write |
| stop_vld | input | 1 | Strobe: STOP condition |
| prot_wr | input | 1 | Strobe: write attempted to a protected array block |
| creg | output | 8 | Current register contents |
| resp_vld | output | 1 | One cycle after a data byte to the register address |
| resp_ack | output | 1 | 1 = ACK, 0 = NACK, valid with resp_vld |
| nv_start | output | 1 | One-cycle pulse starting a nonvolatile cycle |
| busy | output | 1 | Nonvolatile cycle in progress |

## Verification
The hardest state to reach from the ports is a data byte that arrives inside the nonvolatile busy window while the write-enable latch is still set. Reaching it first needs the full unlock sequence and a commit, and then a byte placed before the cycle count runs out. A close second is a commit-shaped byte with the register-write latch armed that is then cut off by a second byte or a repeated start. The bench tracks the elapsed clock count against the commit edge so that it knows whether each byte falls inside the window. It drives directed unlock, abort and busy sequences, then random transactions biased toward the 02h/06h/commit patterns. This keeps the random phase passing through the armed states often.

// File: rtl/creg_guard_pkg.sv
package creg_guard_pkg;

  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CODE_ARM_WR   = 8'h02;
  localparam logic [BYTE_W-1:0] CODE_ARM_REG  = 8'h06;
  localparam logic [BYTE_W-1:0] CODE_DISARM   = 8'h00;

  typedef struct packed {
    logic [1:0] wd;
    logic [2:0] bp;
  } nv_t;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_SET_WEL,
    ACT_CLR_WEL,
    ACT_SET_RWEL,
    ACT_COMMIT
  } act_e;

  function automatic logic [BYTE_W-1:0] pack_creg(nv_t nv, logic rwel, logic wel);
    return {1'b0, nv.wd, nv.bp[2:1], rwel, wel, nv.bp[0]};
  endfunction

endpackage

// File: rtl/creg_txn_track.sv
module creg_txn_track
  import creg_guard_pkg::*;
#(
  parameter int unsigned         ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]   REG_ADDR = {ADDR_W{1'b1}}
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_vld,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              more_vld,
  input  logic              stop_vld,
  input  logic              accept_ok,
  output logic              resp_vld,
  output logic              resp_ack,
  output logic              apply,
  output logic [BYTE_W-1:0] pend_byte
);

  logic              open_q;
  logic              got_q;
  logic              pend_q;
  logic [BYTE_W-1:0] pbyte_q;
  logic              rvld_q;
  logic              rack_q;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      open_q  <= 1'b0;
      got_q   <= 1'b0;
      pend_q  <= 1'b0;
      pbyte_q <= '0;
      rvld_q  <= 1'b0;
      rack_q  <= 1'b0;
    end else begin
      rvld_q <= 1'b0;
      rack_q <= 1'b0;
      if (addr_vld) begin
        open_q <= (addr == REG_ADDR);
        got_q  <= 1'b0;
        pend_q <= 1'b0;
      end else if (rd_vld || stop_vld) begin
        open_q <= 1'b0;
        got_q  <= 1'b0;
        pend_q <= 1'b0;
      end else if (open_q && byte_vld && !got_q) begin
        got_q   <= 1'b1;
        rvld_q  <= 1'b1;
        rack_q  <= accept_ok;
        pend_q  <= accept_ok;
        pbyte_q <= byte_data;
      end else if (open_q && (byte_vld || more_vld)) begin
        got_q  <= 1'b1;
        rvld_q <= 1'b1;
        rack_q <= 1'b0;
        pend_q <= 1'b0;
      end
    end
  end

  assign apply     = stop_vld && pend_q;
  assign pend_byte = pbyte_q;
  assign resp_vld  = rvld_q;
  assign resp_ack  = rack_q;

  // R9: strobes from the front end are mutually exclusive
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({addr_vld, rd_vld, byte_vld, more_vld, stop_vld}));

  // R8: a refused byte leaves nothing pending
  p_nack_drops_r8: assert property (@(posedge clk) disable iff (!por_n)
    (resp_vld && !resp_ack) |-> !pend_q);

  // R9: a pending byte survives only inside an open register write
  p_pend_open_r9: assert property (@(posedge clk) disable iff (!por_n)
    pend_q |-> open_q);

endmodule

// File: rtl/creg_step_decode.sv
module creg_step_decode
  import creg_guard_pkg::*;
(
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [BYTE_W-1:0] pend_byte,
  input  logic              wel,
  input  logic              rwel,
  input  logic              busy,
  output logic              accept_ok,
  output act_e              act
);

  always_comb begin
    accept_ok = !busy && (wel || (in_byte == CODE_ARM_WR));
  end

  always_comb begin
    act = ACT_NONE;
    if (pend_byte == CODE_DISARM) begin
      act = ACT_CLR_WEL;
    end else if (rwel && (pend_byte[2:1] == 2'b01)) begin
      act = ACT_COMMIT;
    end else if (!rwel && (pend_byte == CODE_ARM_REG)) begin
      act = ACT_SET_RWEL;
    end else if (pend_byte == CODE_ARM_WR) begin
      act = ACT_SET_WEL;
    end
  end

endmodule

// File: rtl/creg_nv_timer.sv
module creg_nv_timer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk,
  input  logic por_n,
  input  logic start,
  output logic busy
);

  localparam int unsigned       CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0]  LOAD  = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);

  // R12: a new cycle is never started on top of a running one
  p_start_idle_r12: assert property (@(posedge clk) disable iff (!por_n)
    start |-> !busy);

  // R5: busy only rises as a result of a start
  p_busy_cause_r5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(busy) |-> $past(start));

endmodule

// File: rtl/creg_guard_seq.sv
module creg_guard_seq
  import creg_guard_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]  REG_ADDR  = {ADDR_W{1'b1}},
  parameter int unsigned        NV_CYCLES = 1000,
  parameter logic [4:0]         NV_INIT   = 5'b00000
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_vld,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              more_vld,
  input  logic              stop_vld,
  input  logic              prot_wr,
  output logic [BYTE_W-1:0] creg,
  output logic              resp_vld,
  output logic              resp_ack,
  output logic              nv_start,
  output logic              busy
);

  logic              wel_q;
  logic              rwel_q;
  logic              start_q;
  nv_t               nv_q = nv_t'(NV_INIT);
  logic              accept_ok;
  logic              apply;
  logic [BYTE_W-1:0] pend_byte;
  act_e              act;
  logic              commit;

  creg_txn_track #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
  ) txn_i (
    .clk       (clk),
    .por_n     (por_n),
    .addr_vld  (addr_vld),
    .addr      (addr),
    .rd_vld    (rd_vld),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .more_vld  (more_vld),
    .stop_vld  (stop_vld),
    .accept_ok (accept_ok),
    .resp_vld  (resp_vld),
    .resp_ack  (resp_ack),
    .apply     (apply),
    .pend_byte (pend_byte)
  );

  creg_step_decode dec_i (
    .in_byte   (byte_data),
    .pend_byte (pend_byte),
    .wel       (wel_q),
    .rwel      (rwel_q),
    .busy      (busy),
    .accept_ok (accept_ok),
    .act       (act)
  );

  creg_nv_timer #(
    .CYCLES (NV_CYCLES)
  ) tmr_i (
    .clk   (clk),
    .por_n (por_n),
    .start (commit),
    .busy  (busy)
  );

  assign commit = apply && (act == ACT_COMMIT);

  always_ff @(posedge clk) begin
    if (!por_n) begin
      wel_q   <= 1'b0;
      rwel_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= commit;
      if (apply) begin
        case (act)
          ACT_SET_WEL:  wel_q  <= 1'b1;
          ACT_CLR_WEL:  wel_q  <= 1'b0;
          ACT_SET_RWEL: rwel_q <= 1'b1;
          ACT_COMMIT:   rwel_q <= 1'b0;
          default:      ;
        endcase
      end
      if (prot_wr) begin
        rwel_q <= 1'b0;
      end
    end
  end

  // nonvolatile bits: no power-on clear, loaded only by a committed write
  always_ff @(posedge clk) begin
    if (por_n && commit) begin
      nv_q.wd <= pend_byte[6:5];
      nv_q.bp <= {pend_byte[4:3], pend_byte[0]};
    end
  end

  assign creg     = pack_creg(nv_q, rwel_q, wel_q);
  assign nv_start = start_q;

  // R5: the nonvolatile bits move only together with a start pulse
  p_nv_only_commit_r5: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(nv_q) |-> nv_start);

  // R5: the start pulse lasts one cycle
  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!por_n)
    nv_start |=> !nv_start);

  // R12: no ACK for a byte that arrived during a busy cycle
  p_nack_busy_r12: assert property (@(posedge clk) disable iff (!por_n)
    (resp_vld && $past(busy)) |-> !resp_ack);

  // R2: with write enable clear, only the arming byte is acknowledged
  p_nack_locked_r2: assert property (@(posedge clk) disable iff (!por_n)
    (resp_vld && resp_ack && !$past(wel_q)) |-> ($past(byte_data) == CODE_ARM_WR));

  // R11: a protected-block write leaves the register-write latch clear
  p_prot_clears_r11: assert property (@(posedge clk) disable iff (!por_n)
    prot_wr |=> !rwel_q);

endmodule

// File: tb/creg_guard_seq_tb_top.sv
module creg_guard_seq_tb_top;

  localparam int         NVC   = 40;
  localparam logic [4:0] NV0   = 5'b10110;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        addr_vld = 1'b0;
  logic [15:0] addr = '0;
  logic        rd_vld = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        more_vld = 1'b0;
  logic        stop_vld = 1'b0;
  logic        prot_wr = 1'b0;
  logic [7:0]  creg;
  logic        resp_vld;
  logic        resp_ack;
  logic        nv_start;
  logic        busy;

  creg_guard_seq #(
    .ADDR_W    (16),
    .REG_ADDR  (16'hFFFF),
    .NV_CYCLES (NVC),
    .NV_INIT   (NV0)
  ) dut_i (
    .clk       (clk),
    .por_n     (por_n),
    .addr_vld  (addr_vld),
    .addr      (addr),
    .rd_vld    (rd_vld),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .more_vld  (more_vld),
    .stop_vld  (stop_vld),
    .prot_wr   (prot_wr),
    .creg      (creg),
    .resp_vld  (resp_vld),
    .resp_ack  (resp_ack),
    .nv_start  (nv_start),
    .busy      (busy)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;

  // reference model
  bit       m_wel = 0;
  bit       m_rwel = 0;
  bit [4:0] m_nv = NV0;   // {wd1, wd0, bp2, bp1, bp0}
  int       busy_until = 0;

  function automatic bit m_busy();
    return cyc < busy_until;
  endfunction

  function automatic [7:0] exp_creg();
    return {1'b0, m_nv[4:3], m_nv[2:1], m_rwel, m_wel, m_nv[0]};
  endfunction

  function automatic bit exp_ack(input [7:0] d);
    return !m_busy() && (m_wel || d == 8'h02);
  endfunction

  // applies an accepted byte at STOP; returns 1 on a commit
  function automatic bit model_stop(input [7:0] d);
    if (d == 8'h00) begin
      m_wel = 0;
      return 0;
    end
    if (m_rwel && d[2:1] == 2'b01) begin
      m_nv = {d[6:5], d[4:3], d[0]};
      m_rwel = 0;
      return 1;
    end
    if (!m_rwel && d == 8'h06) begin
      m_rwel = 1;
      return 0;
    end
    if (d == 8'h02) m_wel = 1;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // term: 0 STOP, 1 second byte then STOP, 2 repeated start into read then STOP, 3 STOP before data byte
  task automatic reg_write(input [15:0] a, input [7:0] d, input int term);
    bit is_reg = (a == 16'hFFFF);
    bit pend = 0;
    bit ackx;
    bit cm = 0;
    @(negedge clk);
    addr_vld = 1; addr = a;
    @(negedge clk);
    addr_vld = 0;
    if (term != 3) begin
      byte_data = d; byte_vld = 1;
      ackx = exp_ack(d);
      @(negedge clk);
      byte_vld = 0;
      chk(resp_vld == is_reg, "R9 response only for register address", resp_vld, is_reg);
      if (is_reg) begin
        if (m_busy())
          chk(resp_ack == ackx, "R12 ack during busy", resp_ack, ackx);
        else if (!m_wel)
          chk(resp_ack == ackx, "R2/R3 ack with write enable clear", resp_ack, ackx);
        else
          chk(resp_ack == ackx, "R3 ack with write enable set", resp_ack, ackx);
      end
      pend = is_reg && ackx;
    end
    if (term == 1) begin
      more_vld = 1;
      @(negedge clk);
      more_vld = 0;
      if (is_reg) chk(resp_vld && !resp_ack, "R8 second byte NACK", {resp_vld, resp_ack}, 2'b10);
      pend = 0;
    end
    if (term == 2) begin
      rd_vld = 1;
      @(negedge clk);
      rd_vld = 0;
      pend = 0;
    end
    stop_vld = 1;
    if (pend) begin
      cm = model_stop(d);
      if (cm) busy_until = cyc + 1 + NVC;
    end
    @(negedge clk);
    stop_vld = 0;
    chk(nv_start == cm, "R5 nv_start pulse", nv_start, cm);
    chk(creg == exp_creg(), term == 0 ? "R13 register after write" : "R8/R9 aborted write", creg, exp_creg());
    chk(busy == m_busy(), "R5 busy", busy, m_busy());
    if (cm) begin
      @(negedge clk);
      chk(nv_start == 1'b0, "R5 nv_start one cycle", nv_start, 0);
    end
  endtask

  task automatic rd_txn();
    @(negedge clk);
    rd_vld = 1;
    @(negedge clk);
    rd_vld = 0; stop_vld = 1;
    @(negedge clk);
    stop_vld = 0;
    chk(creg == exp_creg(), "R10 read leaves register", creg, exp_creg());
  endtask

  task automatic prot_pulse();
    @(negedge clk);
    prot_wr = 1;
    m_rwel = 0;
    @(negedge clk);
    prot_wr = 0;
    chk(creg[2] == 1'b0 && creg == exp_creg(), "R11 protected write clears RWEL", creg, exp_creg());
  endtask

  task automatic power_on();
    @(negedge clk);
    por_n = 0;
    repeat (3) @(negedge clk);
    por_n = 1;
    m_wel = 0; m_rwel = 0; busy_until = 0;
    @(negedge clk);
    chk(creg == exp_creg(), "R1 reset register, nonvolatile bits kept", creg, exp_creg());
    chk(!busy && !nv_start && !resp_vld, "R1 reset outputs", {busy, nv_start, resp_vld}, 0);
  endtask

  task automatic wait_idle();
    while (m_busy()) @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R5 busy ends after NV_CYCLES", busy, 0);
  endtask

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd9173);
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    chk(creg == {1'b0, NV0[4:3], NV0[2:1], 2'b00, NV0[0]}, "R1 reset state", creg, exp_creg());
    chk(!busy && !nv_start && !resp_vld, "R1 reset outputs", {busy, nv_start, resp_vld}, 0);

    // R2: locked writes refused
    reg_write(16'hFFFF, 8'h06, 0);
    reg_write(16'hFFFF, 8'h55, 0);
    // R3 / R4
    reg_write(16'hFFFF, 8'h02, 0);
    chk(creg[1] == 1'b1, "R3 WEL set", creg[1], 1);
    rd_txn();  // R10 between steps
    reg_write(16'hFFFF, 8'h06, 0);
    chk(creg[2] == 1'b1, "R4 RWEL set", creg[2], 1);
    rd_txn();  // R10
    // R5 commit with bit7 set -> R13 bit7 reads 0
    reg_write(16'hFFFF, 8'hEB, 0);
    chk(creg == 8'h6B, "R13 layout after commit", creg, 8'h6B);
    // R12 bytes during busy
    reg_write(16'hFFFF, 8'h02, 0);
    reg_write(16'hFFFF, 8'h06, 0);
    wait_idle();
    // R6: 06h with RWEL set keeps bits
    reg_write(16'hFFFF, 8'h06, 0);
    reg_write(16'hFFFF, 8'h06, 0);
    chk(creg == 8'h6F, "R6 06h keeps nonvolatile bits", creg, 8'h6F);
    // R6: 02h with RWEL set clears nonvolatile bits
    reg_write(16'hFFFF, 8'h02, 0);
    chk(creg == 8'h02, "R6 02h clears nonvolatile bits", creg, 8'h02);
    wait_idle();
    // R8: commit byte with second byte
    reg_write(16'hFFFF, 8'h06, 0);
    reg_write(16'hFFFF, 8'h7B, 1);
    chk(creg == 8'h06, "R8 aborted commit", creg, 8'h06);
    // R9: repeated start, stop before byte, other address
    reg_write(16'hFFFF, 8'h7B, 2);
    reg_write(16'hFFFF, 8'h7B, 3);
    reg_write(16'h0123, 8'h00, 0);
    chk(creg == 8'h06, "R9 discarded writes", creg, 8'h06);
    // R11
    prot_pulse();
    reg_write(16'hFFFF, 8'h7B, 0);
    chk(creg == 8'h02, "R11 no commit after protected write", creg, 8'h02);
    // R7
    reg_write(16'hFFFF, 8'h00, 0);
    chk(creg[1] == 1'b0, "R7 WEL cleared", creg[1], 0);
    // R1: power-on keeps nonvolatile bits
    reg_write(16'hFFFF, 8'h02, 0);
    reg_write(16'hFFFF, 8'h06, 0);
    reg_write(16'hFFFF, 8'h53, 0);
    power_on();
    chk(creg == 8'h51, "R1 nonvolatile bits survive reset", creg, 8'h51);

    // random phase
    for (int i = 0; i < 400; i++) begin
      int sel;
      int t;
      bit [7:0] d;
      sel = $urandom_range(0, 11);
      t = $urandom_range(0, 9);
      t = (t < 6) ? 0 : (t - 6);
      case ($urandom_range(0, 4))
        0: d = 8'h02;
        1: d = 8'h06;
        2: d = 8'h00;
        3: d = (8'($urandom) & 8'hF9) | 8'h02;
        default: d = 8'($urandom);
      endcase
      if (sel < 7)       reg_write(16'hFFFF, d, t);
      else if (sel == 7) rd_txn();
      else if (sel == 8) prot_pulse();
      else if (sel == 9) reg_write(16'($urandom), d, 0);
      else if (sel == 10) repeat ($urandom_range(0, 30)) @(negedge clk);
      else if ($urandom_range(0, 3) == 0) power_on();
    end
    wait_idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule